// File: doc/BRIEF.md
# Host Mailbox Buffer with Request Handshake

This block is a small byte-wide message buffer that sits between an external host and an embedded processor. The host sees three byte registers: a buffer pointer, a data window into a 64-byte RAM, and a status byte carrying a request-pending flag. To send a command, the host sets the pointer to zero and streams the message through the data window. The first byte is a command code, the second a message tag, and payload follows. The pointer advances by one on every data-window access. The host then raises the request flag and polls status until the flag drops.

The processor side has a random-access port into the same RAM, a one-cycle notification when the request flag rises, and a strobe that clears the flag once the reply is in place. The reply is written from location 0 with the same two header bytes. The host collects it by writing zero to the pointer and reading the data window repeatedly. The flag can only be changed by a host status write that also carries the load-enable bit, so a stray status write cannot start or cancel a request.

Top module: `host_mailbox`

## Requirements
- R1: After reset the pointer reads 0, the status byte reads 0x00, and both reqPending and reqPulse are 0.
- R2: A host write to offset 0xA6 loads the pointer with the write data modulo 64. A host read of 0xA6 returns the pointer with bits 7:6 zero.
- R3: A host write to offset 0xA7 stores the byte at the current pointer, and the pointer then increments by one.
- R4: A host read of offset 0xA7 returns the byte at the current pointer, and the pointer then increments by one.
- R5: The pointer wraps from 63 to 0 on a data-window access.
- R6: On a host write to status (0xA8), bit 1 is the load-enable bit. It is stored and reads back at bit 1 of status. When bit 1 is 0, the request flag is unchanged.
- R7: A host status write with bit 1 set loads the request flag (status bit 0, also the reqPending output) from write bit 0. This can set the flag or clear it.
- R8: reqPulse is high for exactly the one cycle in which reqPending goes from 0 to 1, and at no other time.
- R9: procClr clears the request flag. If a host status write with load-enable set falls in the same cycle, the host write decides the flag.
- R10: The processor port reads (combinationally) and writes any buffer byte by absolute address. Both sides see each other's data. When both write the same byte in one cycle, the host byte is kept.
- R11: Host accesses to any other offset change nothing and read as 0x00. Reads of the pointer or status register do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe (wins over hostRe) |
| hostRe | input | 1 | Host register read strobe |
| hostAddr | input | 8 | Host register offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational) |
| procWe | input | 1 | Processor buffer write strobe |
| procAddr | input | 6 | Processor buffer address |
| procWdata | input | 8 | Processor write byte |
| procRdata | output | 8 | Processor read byte (combinational) |
| procClr | input | 1 | Processor clear-request strobe |
| reqPending | output | 1 | Request flag |
| reqPulse | output | 1 | One-cycle pulse on the flag's rising edge |

## Verification
Two pairs of functions can meet in one cycle. The first is the processor's clear strobe and a host status write. The bench drives both together with the flag low, with the flag already high, and with the load-enable bit absent. It expects the host write to win only when load-enable is set, and it expects a pulse only on a genuine 0-to-1 change. The second is a host data write and a processor write to the same byte in one cycle. That byte is then read from both ports, and the bench expects the host value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] PTR_OFS  = 8'hA6;
  localparam logic [7:0] DATA_OFS = 8'hA7;
  localparam logic [7:0] STAT_OFS = 8'hA8;
  localparam int REQ_BIT  = 0;
  localparam int LDEN_BIT = 1;

  typedef struct packed {
    logic ptrLoad;
    logic dataWrite;
    logic dataRead;
  } hostStrobeT;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic             hostRe,
  input  logic [AW-1:0]    hostAddr,
  input  logic [1:0]       hostCtl,
  input  logic             procClr,
  input  logic [PTR_W-1:0] ptr,
  input  logic [DW-1:0]    bufByte,
  output hostStrobeT       strobe,
  output logic [DW-1:0]    hostRdata,
  output logic             reqPending,
  output logic             reqPulse
);
  logic ldEn;
  logic reqNext;
  logic statWr;
  logic rdOnly;

  assign rdOnly = hostRe & ~hostWe;
  assign statWr = hostWe && (hostAddr == AW'(STAT_OFS));

  always_comb begin
    strobe.ptrLoad   = hostWe && (hostAddr == AW'(PTR_OFS));
    strobe.dataWrite = hostWe && (hostAddr == AW'(DATA_OFS));
    strobe.dataRead  = rdOnly && (hostAddr == AW'(DATA_OFS));
  end

  // host write with load-enable outranks the processor clear
  always_comb begin
    reqNext = reqPending;
    if (statWr && hostCtl[LDEN_BIT]) reqNext = hostCtl[REQ_BIT];
    else if (procClr)                reqNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPending <= 1'b0;
      reqPulse   <= 1'b0;
      ldEn       <= 1'b0;
    end else begin
      reqPending <= reqNext;
      reqPulse   <= reqNext & ~reqPending;
      if (statWr) ldEn <= hostCtl[LDEN_BIT];
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostAddr == AW'(PTR_OFS)) begin
      hostRdata = DW'(ptr);
    end else if (hostAddr == AW'(DATA_OFS)) begin
      hostRdata = bufByte;
    end else if (hostAddr == AW'(STAT_OFS)) begin
      hostRdata[REQ_BIT]  = reqPending;
      hostRdata[LDEN_BIT] = ldEn;
    end
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStrobeT       strobe,
  input  logic [DW-1:0]    hostWdata,
  input  logic             procWe,
  input  logic [PTR_W-1:0] procAddr,
  input  logic [DW-1:0]    procWdata,
  output logic [PTR_W-1:0] ptr,
  output logic [DW-1:0]    bufByte,
  output logic [DW-1:0]    procRdata
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic procKeep;

  assign procKeep = procWe && !(strobe.dataWrite && (procAddr == ptr));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.ptrLoad) begin
      ptr <= hostWdata[PTR_W-1:0];
    end else if (strobe.dataWrite || strobe.dataRead) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.dataWrite) mem[ptr] <= hostWdata;
    if (procKeep)         mem[procAddr] <= procWdata;
  end

  assign bufByte   = mem[ptr];
  assign procRdata = mem[procAddr];
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic             hostRe,
  input  logic [AW-1:0]    hostAddr,
  input  logic [DW-1:0]    hostWdata,
  output logic [DW-1:0]    hostRdata,
  input  logic             procWe,
  input  logic [PTR_W-1:0] procAddr,
  input  logic [DW-1:0]    procWdata,
  output logic [DW-1:0]    procRdata,
  input  logic             procClr,
  output logic             reqPending,
  output logic             reqPulse
);
  hostStrobeT       strobe;
  logic [PTR_W-1:0] ptr;
  logic [DW-1:0]    bufByte;

  mbox_ctrl #(.AW(AW), .DW(DW), .PTR_W(PTR_W)) u_ctrl (
    .clk, .rstN, .hostWe, .hostRe, .hostAddr,
    .hostCtl(hostWdata[1:0]), .procClr, .ptr, .bufByte,
    .strobe, .hostRdata, .reqPending, .reqPulse
  );

  mbox_dpath #(.DW(DW), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_dpath (
    .clk, .rstN, .strobe, .hostWdata, .procWe, .procAddr, .procWdata,
    .ptr, .bufByte, .procRdata
  );
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk
  import mbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWe,
  input logic [AW-1:0]    hostAddr,
  input logic [DW-1:0]    hostWdata,
  input logic             procClr,
  input logic             reqPending,
  input logic             reqPulse,
  input logic [PTR_W-1:0] ptr
);
  logic statLd;
  logic unmapped;
  assign statLd   = hostWe && hostAddr == AW'(STAT_OFS) && hostWdata[LDEN_BIT];
  assign unmapped = hostWe && hostAddr != AW'(PTR_OFS) &&
                    hostAddr != AW'(DATA_OFS) && hostAddr != AW'(STAT_OFS);

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && hostAddr == AW'(PTR_OFS) |=> ptr == $past(hostWdata[PTR_W-1:0]));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && hostAddr == AW'(DATA_OFS) |=> ptr == PTR_W'($past(ptr) + 1'b1));
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && hostAddr == AW'(STAT_OFS) && !hostWdata[LDEN_BIT] && !procClr
    |=> $stable(reqPending));
  // R7
  req_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    statLd |=> reqPending == $past(hostWdata[REQ_BIT]));
  // R8
  pulse_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqPulse |-> reqPending && !$past(reqPending));
  // R8
  pulse_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqPending) |-> reqPulse);
  // R9
  clr_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    procClr && !statLd |=> !reqPending);
  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    unmapped && !procClr |=> $stable(ptr) && $stable(reqPending));
endmodule

bind host_mailbox host_mailbox_chk #(.AW(AW), .DW(DW), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .procClr(procClr), .reqPending(reqPending),
  .reqPulse(reqPulse), .ptr(ptr)
);

// File: tb/tb_host_mailbox.sv
module tb_host_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_PTR = 8'hA6, A_DATA = 8'hA7, A_STAT = 8'hA8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0, hostRe = 1'b0;
  logic [7:0] hostAddr = '0, hostWdata = '0;
  logic [7:0] hostRdata;
  logic procWe = 1'b0;
  logic [5:0] procAddr = '0;
  logic [7:0] procWdata = '0;
  logic [7:0] procRdata;
  logic procClr = 1'b0;
  logic reqPending, reqPulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] expVal[$];
  string expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  host_mailbox dut (
    .clk, .rstN, .hostWe, .hostRe, .hostAddr, .hostWdata, .hostRdata,
    .procWe, .procAddr, .procWdata, .procRdata, .procClr, .reqPending, .reqPulse
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte for each host read cycle
  always @(negedge clk) begin
    if (rstN && hostRe && !hostWe) begin
      if (expVal.size() == 0) begin
        check(1'b0, "unexpected read", hostRdata, 0);
      end else begin
        automatic logic [7:0] e = expVal.pop_front();
        automatic string t = expTag.pop_front();
        check(hostRdata === e, t, hostRdata, e);
      end
    end
  end

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, input logic [7:0] e, input string tag);
    hostRe = 1'b1; hostAddr = a;
    expVal.push_back(e); expTag.push_back(tag);
    @(posedge clk); #1;
    hostRe = 1'b0;
  endtask

  task automatic procWrite(input logic [5:0] a, input logic [7:0] d);
    procWe = 1'b1; procAddr = a; procWdata = d;
    @(posedge clk); #1;
    procWe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1
    check(reqPending == 1'b0, "R1 reqPending", reqPending, 0);
    check(reqPulse == 1'b0, "R1 reqPulse", reqPulse, 0);
    hostRead(A_PTR, 8'h00, "R1 pointer");
    hostRead(A_STAT, 8'h00, "R1 status");

    // R2
    hostWrite(A_PTR, 8'h05);
    hostRead(A_PTR, 8'h05, "R2 pointer load");
    hostWrite(A_PTR, 8'hC7);
    hostRead(A_PTR, 8'h07, "R2 pointer modulo");

    // R3 request message: command, tag, payload
    hostWrite(A_PTR, 8'h00);
    hostWrite(A_DATA, 8'hA1);
    hostWrite(A_DATA, 8'h22);
    hostWrite(A_DATA, 8'h33);
    hostWrite(A_DATA, 8'h44);
    hostRead(A_PTR, 8'h04, "R3 pointer after writes");
    // R4
    hostWrite(A_PTR, 8'h00);
    hostRead(A_DATA, 8'hA1, "R4 byte0");
    hostRead(A_DATA, 8'h22, "R4 byte1");
    hostRead(A_DATA, 8'h33, "R4 byte2");
    hostRead(A_DATA, 8'h44, "R4 byte3");
    hostRead(A_PTR, 8'h04, "R4 pointer after reads");

    // R10 processor sees host bytes, host sees processor reply
    procAddr = 6'd1; #1;
    check(procRdata == 8'h22, "R10 proc read", procRdata, 8'h22);
    procWrite(6'd0, 8'h5A);
    procWrite(6'd1, 8'h6B);
    hostWrite(A_PTR, 8'h00);
    hostRead(A_DATA, 8'h5A, "R10 reply byte0");
    hostRead(A_DATA, 8'h6B, "R10 reply byte1");

    // R5 wrap
    hostWrite(A_PTR, 8'd63);
    hostWrite(A_DATA, 8'h77);
    hostRead(A_PTR, 8'h00, "R5 wrap on write");
    hostWrite(A_PTR, 8'd63);
    hostRead(A_DATA, 8'h77, "R5 last byte");
    hostRead(A_PTR, 8'h00, "R5 wrap on read");

    // R6 no load-enable
    hostWrite(A_STAT, 8'h01);
    check(reqPending == 1'b0, "R6 set ignored", reqPending, 0);
    hostRead(A_STAT, 8'h00, "R6 status after 0x01");
    hostWrite(A_STAT, 8'h02);
    hostRead(A_STAT, 8'h02, "R6 load-enable readback");
    // R7 / R8 set
    hostWrite(A_STAT, 8'h03);
    check(reqPending == 1'b1, "R7 set", reqPending, 1);
    check(reqPulse == 1'b1, "R8 pulse on rise", reqPulse, 1);
    @(posedge clk); #1;
    check(reqPulse == 1'b0, "R8 pulse one cycle", reqPulse, 0);
    hostWrite(A_STAT, 8'h03);
    check(reqPulse == 1'b0, "R8 no pulse when already set", reqPulse, 0);
    hostWrite(A_STAT, 8'h00);
    check(reqPending == 1'b1, "R6 clear ignored", reqPending, 1);
    hostRead(A_STAT, 8'h01, "R6 status after 0x00");
    // R7 host clear
    hostWrite(A_STAT, 8'h02);
    check(reqPending == 1'b0, "R7 host clear", reqPending, 0);

    // R9 processor clear
    hostWrite(A_STAT, 8'h03);
    procClr = 1'b1; @(posedge clk); #1; procClr = 1'b0;
    check(reqPending == 1'b0, "R9 proc clear", reqPending, 0);
    // R9 collision, flag low: host set wins, pulse
    procClr = 1'b1; hostWrite(A_STAT, 8'h03); procClr = 1'b0;
    check(reqPending == 1'b1, "R9 collide low", reqPending, 1);
    check(reqPulse == 1'b1, "R9 collide low pulse", reqPulse, 1);
    // R9 collision, flag high: stays, no pulse
    procClr = 1'b1; hostWrite(A_STAT, 8'h03); procClr = 1'b0;
    check(reqPending == 1'b1, "R9 collide high", reqPending, 1);
    check(reqPulse == 1'b0, "R9 collide high no pulse", reqPulse, 0);
    // R9 collision without load-enable: clear wins
    procClr = 1'b1; hostWrite(A_STAT, 8'h01); procClr = 1'b0;
    check(reqPending == 1'b0, "R9 clear vs plain write", reqPending, 0);

    // R11 unmapped offsets
    hostWrite(A_PTR, 8'd9);
    hostWrite(A_STAT, 8'h03);
    hostWrite(8'h10, 8'hFF);
    hostWrite(8'hA9, 8'h00);
    check(reqPending == 1'b1, "R11 flag untouched", reqPending, 1);
    hostRead(8'h10, 8'h00, "R11 unmapped read");
    hostRead(A_STAT, 8'h03, "R11 status untouched");
    hostRead(A_PTR, 8'd9, "R11 pointer untouched");

    // R10 same-byte write collision: host kept
    hostWrite(A_PTR, 8'd10);
    procWe = 1'b1; procAddr = 6'd10; procWdata = 8'h99;
    hostWrite(A_DATA, 8'h11);
    procWe = 1'b0; #1;
    check(procRdata == 8'h11, "R10 collision proc view", procRdata, 8'h11);
    hostWrite(A_PTR, 8'd10);
    hostRead(A_DATA, 8'h11, "R10 collision host view");

    @(posedge clk); #1;
    check(expVal.size() == 0, "scoreboard drained", expVal.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule